// File: doc/BRIEF.md
# Block-to-Task-File Address Translator

This block turns a linear block number into the four byte values that a disk command needs before it is issued: the sector byte, the low and high cylinder bytes, and the drive/head byte. It has two mappings. In linear-address mode the block number is cut into fields and the drive byte carries the linear-mode flag. In geometry mode the block number is divided by the drive geometry (heads and sectors per track) to get a cylinder, a head and a one-based sector.

A request is a single-cycle start pulse with the block number, the device block count, the mode flag, the geometry and the drive select all presented in that cycle. The result comes back as a one-cycle valid pulse with the four bytes. A block number beyond the device size, or a zero geometry value in geometry mode, returns a one-cycle range-error pulse and no valid. Geometry mode runs two passes through one restoring shift-subtract divider that produces one quotient bit per cycle, so its result takes longer than a linear-mode result.

Top module: `blk_taskfile_xlate`

## Requirements
- R1: In linear mode, sect_o = block[7:0], cyl_lo_o = block[15:8] and cyl_hi_o = block[23:16].
- R2: In linear mode, drive_o = 0xA0 | 0x40 | (slave_i ? 0x10 : 0) | block[26:24]; bit 27 of the block number has no effect on any output byte.
- R3: In geometry mode the cylinder C = block / (heads × sectors); cyl_lo_o = C[7:0] and cyl_hi_o = C[15:8].
- R4: In geometry mode, with T = block mod (heads × sectors), the head H = T / sectors and drive_o = 0xA0 | (slave_i ? 0x10 : 0) | H[7:0].
- R5: In geometry mode sect_o = (T mod sectors) + 1, so it is never zero.
- R6: A block number strictly greater than blk_count_i gives a range_err_o pulse in the cycle after start and no valid_o; a block number equal to blk_count_i is accepted.
- R7: In geometry mode a heads or sectors value of zero gives range_err_o in the cycle after start and no division; in linear mode the geometry inputs have no effect, zero included.
- R8: valid_o is high for exactly one cycle per accepted request; in linear mode it rises in the cycle after start, in geometry mode within 2 × BLK_W + 4 cycles; valid_o and range_err_o are never high together.
- R9: A start pulse that arrives while a geometry-mode request is still being divided is ignored: the pending result is unchanged and no extra valid_o follows.
- R10: After reset valid_o and range_err_o are low and all four output bytes are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request pulse |
| block_i | input | BLK_W | Linear block number |
| blk_count_i | input | BLK_W | Highest block number the device accepts |
| lba_mode_i | input | 1 | 1 = linear mode, 0 = geometry mode |
| heads_i | input | GEO_W | Number of heads |
| spt_i | input | GEO_W | Sectors per track |
| slave_i | input | 1 | Selects the second drive on the channel |
| sect_o | output | 8 | Sector byte |
| cyl_lo_o | output | 8 | Cylinder low byte |
| cyl_hi_o | output | 8 | Cylinder high byte |
| drive_o | output | 8 | Drive/head byte |
| valid_o | output | 1 | One-cycle result pulse |
| range_err_o | output | 1 | One-cycle rejection pulse |

## Verification
Linear mode is driven with a zero block, a mixed-digit block and an all-ones block: together they show that each byte comes from the right field, that bit 27 is dropped and that the slave bit is placed correctly. Geometry mode is driven with block zero, the last block of cylinder zero and the first block of cylinder one at 16 heads and 63 sectors. These three cases separate the quotient from the remainder and catch an off-by-one in the sector base. A single-head, single-sector geometry and an odd geometry with the slave bit set test the divider away from powers of two. The boundary cases are block equal to and one above the count, zero heads, zero sectors, zero geometry in linear mode, and a second start sent during a division.

// File: rtl/blk_xlate_pkg.sv
package blk_xlate_pkg;

  typedef logic [7:0] tf_byte_t;

  // Four register bytes handed to the command issuer.
  typedef struct packed {
    tf_byte_t sect;
    tf_byte_t cyl_lo;
    tf_byte_t cyl_hi;
    tf_byte_t drive;
  } tf_regs_t;

  localparam tf_byte_t DRV_FIXED = 8'hA0;
  localparam tf_byte_t DRV_LINEAR = 8'h40;
  localparam tf_byte_t DRV_SECOND = 8'h10;

  typedef enum logic [1:0] {
    XL_IDLE = 2'd0,
    XL_CYL  = 2'd1,
    XL_HEAD = 2'd2
  } xl_state_e;

endpackage

// File: rtl/blk_div_restore.sv
module blk_div_restore #(
  parameter int N = 28
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go_i,
  input  logic [N-1:0] dividend_i,
  input  logic [N-1:0] divisor_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [N-1:0] quo_o,
  output logic [N-1:0] rem_o
);

  localparam int CW = $clog2(N + 1);

  logic [N:0]    part_q;
  logic [N-1:0]  shq_q;
  logic [N-1:0]  dvs_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q;
  logic          done_q;

  // one trial subtraction per cycle
  logic [N:0] shifted;
  logic [N:0] trial;
  logic       fits;
  logic       last_step;

  assign shifted   = {part_q[N-1:0], shq_q[N-1]};
  assign trial     = shifted - {1'b0, dvs_q};
  assign fits      = ~trial[N];
  assign last_step = busy_q && (cnt_q == CW'(N - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      part_q <= '0;
      shq_q  <= '0;
      dvs_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q && go_i) begin
        part_q <= '0;
        shq_q  <= dividend_i;
        dvs_q  <= divisor_i;
        cnt_q  <= '0;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        part_q <= fits ? trial : shifted;
        shq_q  <= {shq_q[N-2:0], fits};
        cnt_q  <= cnt_q + 1'b1;
        if (last_step) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign quo_o  = shq_q;
  assign rem_o  = part_q[N-1:0];

  // R5: a finished division always leaves a remainder below the divisor
  a_r5_rem_below_divisor: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && dvs_q != '0) |-> (rem_o < dvs_q));

  // R8: completion is a single-cycle event
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

endmodule

// File: rtl/blk_tf_pack.sv
module blk_tf_pack
  import blk_xlate_pkg::*;
#(
  parameter int BLK_W = 28,
  parameter int CYL_W = 16
) (
  input  logic             linear_i,
  input  logic             second_i,
  input  logic [BLK_W-1:0] block_i,
  input  logic [CYL_W-1:0] cyl_i,
  input  logic [7:0]       head_i,
  input  logic [7:0]       srem_i,
  output tf_regs_t         regs_o
);

  // linear mode: block fields go straight into the bytes
  function automatic tf_regs_t pack_linear(input logic [BLK_W-1:0] blk,
                                           input logic sec);
    tf_regs_t r;
    r.sect   = blk[7:0];
    r.cyl_lo = blk[15:8];
    r.cyl_hi = blk[23:16];
    r.drive  = DRV_FIXED | DRV_LINEAR | (sec ? DRV_SECOND : 8'h00)
             | {5'b0, blk[26:24]};
    return r;
  endfunction

  // geometry mode: sector numbering starts at one
  function automatic tf_regs_t pack_geom(input logic [CYL_W-1:0] cyl,
                                         input logic [7:0] head,
                                         input logic [7:0] srem,
                                         input logic sec);
    tf_regs_t r;
    r.sect   = srem + 8'd1;
    r.cyl_lo = cyl[7:0];
    r.cyl_hi = cyl[15:8];
    r.drive  = DRV_FIXED | (sec ? DRV_SECOND : 8'h00) | head;
    return r;
  endfunction

  assign regs_o = linear_i ? pack_linear(block_i, second_i)
                           : pack_geom(cyl_i, head_i, srem_i, second_i);

endmodule

// File: rtl/blk_taskfile_xlate.sv
module blk_taskfile_xlate
  import blk_xlate_pkg::*;
#(
  parameter int BLK_W = 28,
  parameter int GEO_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [BLK_W-1:0] block_i,
  input  logic [BLK_W-1:0] blk_count_i,
  input  logic             lba_mode_i,
  input  logic [GEO_W-1:0] heads_i,
  input  logic [GEO_W-1:0] spt_i,
  input  logic             slave_i,
  output logic [7:0]       sect_o,
  output logic [7:0]       cyl_lo_o,
  output logic [7:0]       cyl_hi_o,
  output logic [7:0]       drive_o,
  output logic             valid_o,
  output logic             range_err_o
);

  localparam int CYL_W  = 16;
  localparam int PROD_W = 2 * GEO_W;  // BLK_W must be at least PROD_W and 27

  xl_state_e        state_q;
  logic [GEO_W-1:0] spt_q;
  logic             second_q;
  logic [CYL_W-1:0] cyl_q;
  tf_regs_t         regs_q;
  logic             valid_q;
  logic             err_q;

  // named events for the assertions
  logic             idle;
  logic             accept;
  logic             too_far;
  logic             geo_zero;
  logic             reject;
  logic             take_linear;
  logic             take_geom;
  logic             cyl_done;
  logic             head_done;

  logic [PROD_W-1:0] hs_prod;
  logic              div_go;
  logic [BLK_W-1:0]  div_dividend;
  logic [BLK_W-1:0]  div_divisor;
  logic              div_busy;
  logic              div_done;
  logic [BLK_W-1:0]  div_quo;
  logic [BLK_W-1:0]  div_rem;
  tf_regs_t          pack_regs;

  assign idle        = (state_q == XL_IDLE);
  assign accept      = idle && start_i;
  assign too_far     = block_i > blk_count_i;
  assign geo_zero    = !lba_mode_i && (heads_i == '0 || spt_i == '0);
  assign reject      = accept && (too_far || geo_zero);
  assign take_linear = accept && !reject && lba_mode_i;
  assign take_geom   = accept && !reject && !lba_mode_i;
  assign cyl_done    = (state_q == XL_CYL) && div_done;
  assign head_done   = (state_q == XL_HEAD) && div_done;

  assign hs_prod      = heads_i * spt_i;
  assign div_go       = take_geom || cyl_done;
  assign div_dividend = idle ? block_i : div_rem;
  assign div_divisor  = idle ? BLK_W'(hs_prod) : BLK_W'(spt_q);

  blk_div_restore #(.N(BLK_W)) u_div (
    .clk        (clk),
    .rst_n      (rst_n),
    .go_i       (div_go),
    .dividend_i (div_dividend),
    .divisor_i  (div_divisor),
    .busy_o     (div_busy),
    .done_o     (div_done),
    .quo_o      (div_quo),
    .rem_o      (div_rem)
  );

  blk_tf_pack #(.BLK_W(BLK_W), .CYL_W(CYL_W)) u_pack (
    .linear_i (idle),
    .second_i (idle ? slave_i : second_q),
    .block_i  (block_i),
    .cyl_i    (cyl_q),
    .head_i   (div_quo[7:0]),
    .srem_i   (div_rem[7:0]),
    .regs_o   (pack_regs)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= XL_IDLE;
      spt_q    <= '0;
      second_q <= 1'b0;
      cyl_q    <= '0;
      regs_q   <= '0;
      valid_q  <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      err_q   <= reject;
      unique case (state_q)
        XL_IDLE: begin
          if (take_linear) begin
            regs_q  <= pack_regs;
            valid_q <= 1'b1;
          end else if (take_geom) begin
            spt_q    <= spt_i;
            second_q <= slave_i;
            state_q  <= XL_CYL;
          end
        end
        XL_CYL: begin
          if (div_done) begin
            cyl_q   <= div_quo[CYL_W-1:0];
            state_q <= XL_HEAD;
          end
        end
        XL_HEAD: begin
          if (div_done) begin
            regs_q  <= pack_regs;
            valid_q <= 1'b1;
            state_q <= XL_IDLE;
          end
        end
        default: state_q <= XL_IDLE;
      endcase
    end
  end

  assign sect_o      = regs_q.sect;
  assign cyl_lo_o    = regs_q.cyl_lo;
  assign cyl_hi_o    = regs_q.cyl_hi;
  assign drive_o     = regs_q.drive;
  assign valid_o     = valid_q;
  assign range_err_o = err_q;

  // R8: result and rejection never coincide
  a_r8_valid_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid_o && range_err_o));

  // R8: the result is a one-cycle pulse
  a_r8_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  // R2 / R4: fixed drive-byte bits present on every result
  a_r4_drive_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (drive_o[7] && drive_o[5]));

  // R6: a rejected request launches no division
  a_r6_reject_no_div: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> !div_busy);

  // R9: outside idle a start never reloads the divider
  a_r9_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == XL_CYL && !div_done) |-> !div_go);

  // R5: a geometry result never carries sector zero
  a_r5_sector_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !drive_o[6]) |-> (sect_o != 8'd0));

endmodule

// File: tb/sim_blk_taskfile_xlate.sv
module sim_blk_taskfile_xlate;

  localparam int BLK_W = 28;
  localparam int GEO_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start_i = 1'b0;
  logic [BLK_W-1:0] block_i = '0;
  logic [BLK_W-1:0] blk_count_i = '0;
  logic             lba_mode_i = 1'b0;
  logic [GEO_W-1:0] heads_i = '0;
  logic [GEO_W-1:0] spt_i = '0;
  logic             slave_i = 1'b0;
  logic [7:0]       sect_o, cyl_lo_o, cyl_hi_o, drive_o;
  logic             valid_o, range_err_o;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;

  // result of the last request
  int          r_lat;
  logic        r_valid, r_err;
  logic [31:0] r_bytes;

  always #2 clk = ~clk;

  blk_taskfile_xlate #(.BLK_W(BLK_W), .GEO_W(GEO_W)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .block_i(block_i),
    .blk_count_i(blk_count_i), .lba_mode_i(lba_mode_i), .heads_i(heads_i),
    .spt_i(spt_i), .slave_i(slave_i), .sect_o(sect_o), .cyl_lo_o(cyl_lo_o),
    .cyl_hi_o(cyl_hi_o), .drive_o(drive_o), .valid_o(valid_o),
    .range_err_o(range_err_o));

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] exp_linear(input logic [27:0] b, input logic sl);
    logic [7:0] d;
    d = 8'hE0 + (sl ? 8'h10 : 8'h00) + {5'b0, b[26:24]};
    return {b[7:0], b[15:8], b[23:16], d};
  endfunction

  function automatic logic [31:0] exp_geom(input int b, input int h, input int s, input logic sl);
    int c, t, hd, sc;
    logic [7:0] d;
    c  = b / (h * s);
    t  = b % (h * s);
    hd = t / s;
    sc = (t % s) + 1;
    d  = 8'hA0 | (sl ? 8'h10 : 8'h00) | 8'(hd);
    return {8'(sc), 8'(c), 8'(c >> 8), d};
  endfunction

  // drive one request, wait for the answer
  task automatic issue(input logic [27:0] b, input logic [27:0] cnt, input logic lin,
                       input int h, input int s, input logic sl);
    @(negedge clk);
    block_i = b; blk_count_i = cnt; lba_mode_i = lin;
    heads_i = 8'(h); spt_i = 8'(s); slave_i = sl; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    r_lat = 1;
    while (!valid_o && !range_err_o && r_lat < 200) begin
      @(negedge clk);
      r_lat++;
    end
    r_valid = valid_o;
    r_err   = range_err_o;
    r_bytes = {sect_o, cyl_lo_o, cyl_hi_o, drive_o};
    @(negedge clk);
    check("R8 one-cycle pulse", {31'b0, valid_o | range_err_o}, 32'd0);
  endtask

  task automatic t_reset;
    check("R10 reset bytes", {sect_o, cyl_lo_o, cyl_hi_o, drive_o}, 32'd0);
    check("R10 reset flags", {30'b0, valid_o, range_err_o}, 32'd0);
  endtask

  task automatic t_linear(input logic [27:0] b, input logic sl, input int h, input int s);
    issue(b, 28'hFFFFFFF, 1'b1, h, s, sl);
    check("R8 linear latency", r_lat, 1);
    check("R8 linear valid", {31'b0, r_valid}, 1);
    check("R1 R2 linear bytes", r_bytes, exp_linear(b, sl));
  endtask

  task automatic t_geom(input int b, input int cnt, input int h, input int s, input logic sl);
    issue(28'(b), 28'(cnt), 1'b0, h, s, sl);
    check("R8 geometry valid", {31'b0, r_valid}, 1);
    check("R8 geometry latency bound", {31'b0, r_lat <= 2 * BLK_W + 4}, 1);
    check("R3 R4 R5 geometry bytes", r_bytes, exp_geom(b, h, s, sl));
  endtask

  task automatic t_reject(input string req, input logic [27:0] b, input logic [27:0] cnt,
                          input logic lin, input int h, input int s);
    issue(b, cnt, lin, h, s, 1'b0);
    check({req, " error raised"}, {31'b0, r_err}, 1);
    check({req, " error latency"}, r_lat, 1);
    check({req, " no valid"}, {31'b0, r_valid}, 0);
  endtask

  task automatic t_busy_ignore;
    int extra;
    @(negedge clk);
    block_i = 28'd2000; blk_count_i = 28'hFFFFFFF; lba_mode_i = 1'b0;
    heads_i = 8'd16; spt_i = 8'd63; slave_i = 1'b0; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (5) @(negedge clk);
    block_i = 28'h0123456; lba_mode_i = 1'b1; slave_i = 1'b1; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    r_lat = 0;
    while (!valid_o && r_lat < 200) begin
      @(negedge clk);
      r_lat++;
    end
    check("R9 pending result kept", {sect_o, cyl_lo_o, cyl_hi_o, drive_o},
          exp_geom(2000, 16, 63, 1'b0));
    extra = 0;
    repeat (80) begin
      @(negedge clk);
      if (valid_o) extra++;
    end
    check("R9 no extra valid", extra, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1 R2 linear patterns
    t_linear(28'h0000000, 1'b0, 16, 63);
    t_linear(28'h0ABCDEF, 1'b0, 16, 63);
    t_linear(28'hFFFFFFF, 1'b1, 16, 63);
    // R7 linear mode ignores zero geometry
    t_linear(28'h5A5A5A5, 1'b1, 0, 0);
    // R3 R4 R5 geometry patterns
    t_geom(0, 100000, 16, 63, 1'b0);
    t_geom(1007, 100000, 16, 63, 1'b0);
    t_geom(1008, 100000, 16, 63, 1'b0);
    t_geom(300, 100000, 1, 1, 1'b0);
    t_geom(777777, 1000000, 15, 17, 1'b1);
    // R6 boundary: equal accepted, one above rejected
    t_geom(5000, 5000, 16, 63, 1'b1);
    t_reject("R6 block above count", 28'd5001, 28'd5000, 1'b0, 16, 63);
    t_reject("R6 linear above count", 28'd10, 28'd9, 1'b1, 16, 63);
    // R7 zero geometry in geometry mode
    t_reject("R7 zero heads", 28'd5, 28'd100, 1'b0, 0, 63);
    t_reject("R7 zero sectors", 28'd5, 28'd100, 1'b0, 16, 0);
    // R9 start during a division
    t_busy_ignore();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, got %0d cycles expected fewer", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule